// File: doc/BRIEF.md
# Prefix-Extended Byte Instruction Decoder

This block turns a stream of one-byte instructions into decoded instructions that carry a full-width operand. The upper nibble of each byte is a function code and the lower nibble is a data value. Two prefix functions build longer operands. Each one folds its nibble into an operand register that is held between bytes. The next non-prefix byte then gets the whole accumulated value as its operand. The positive prefix shifts the register as it stands. The negative prefix complements the register before the shift, so negative operands can be built. A third function, "operate", marks the operand as a selector for the less frequent operations.

Bytes arrive on a valid/ready stream, and the decoder takes at most one byte per clock. Each non-prefix byte produces one registered output. The output carries the function code, the operand, the number of prefix bytes that came before it, and two flags: one for a multi-byte operand and one for an operate selector. While the consumer holds back a pending output, no further byte is taken in. Executing the instructions is left to downstream logic.

Top module: `nibble_chain_decoder`

## Requirements
- R1: After reset, `out_valid` is 0, `in_ready` is 1, and the operand register and prefix count are zero.
- R2: A non-prefix byte accepted on a clock edge appears on the output right after that edge. `out_valid`=1, `out_func` is byte bits [7:4], and `out_operand` is the prefix-built value shifted left by 4 with byte bits [3:0] in its low nibble.
- R3: Function 0xA is the positive prefix. It sets operand := (operand << 4) | data and produces no output.
- R4: Function 0xB is the negative prefix. It sets operand := ((~operand) << 4) | data and produces no output.
- R5: After each non-prefix byte is taken, the operand register and prefix count return to zero.
- R6: `out_pfx_cnt` is the number of prefix bytes taken since the previous non-prefix byte, saturating at 15. `out_multi` is 1 exactly when that count is non-zero.
- R7: Function 0xF is "operate". It is emitted like any non-prefix byte, with `out_is_op`=1. For every other function, `out_is_op` is 0.
- R8: While `out_valid`=1 and `out_ready`=0, `in_ready` is 0 and all output fields hold their values.
- R9: While `out_ready` stays 1, one byte is taken on every clock and each non-prefix byte's result appears on the following cycle.
- R10: Operand bits shifted above bit 31 are discarded, so only the last eight nibbles of a chain are kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Instruction byte offered |
| in_byte | input | 8 | Function code in [7:4], data nibble in [3:0] |
| in_ready | output | 1 | Decoder takes the byte this cycle |
| out_valid | output | 1 | Decoded instruction pending |
| out_ready | input | 1 | Consumer takes the decoded instruction |
| out_func | output | 4 | Function code of the instruction |
| out_operand | output | 32 | Full operand built from prefixes and data |
| out_pfx_cnt | output | 4 | Prefix bytes before this instruction (saturating) |
| out_multi | output | 1 | Operand used more than one byte |
| out_is_op | output | 1 | Instruction is the operate selector |

## Verification
The main function is tried in several ways:
- a lone byte, which shows that the operand is zero-extended and that the register starts clear;
- chains of positive prefixes, which separate correct shift-then-OR ordering from a swapped nibble order;
- negative chains, whose expected values tell complement-before-shift apart from complement-after-shift;
- a nine-byte chain and a sixteen-prefix run, which expose truncation and count saturation.

Stall and back-to-back streams show whether bytes are lost or duplicated at the output handshake.

// File: rtl/ncd_pkg.sv
package ncd_pkg;

    localparam int NIB_W = 4;

    localparam logic [NIB_W-1:0] FN_EXT_POS  = 4'hA;
    localparam logic [NIB_W-1:0] FN_EXT_NEG  = 4'hB;
    localparam logic [NIB_W-1:0] FN_OPERATE  = 4'hF;

    typedef enum logic [1:0] {
        K_PLAIN   = 2'd0,
        K_EXT_POS = 2'd1,
        K_EXT_NEG = 2'd2,
        K_OPERATE = 2'd3
    } kind_e;

    typedef struct packed {
        logic [NIB_W-1:0] fn;
        logic [NIB_W-1:0] dat;
    } byte_fields_t;

    function automatic kind_e classify(input logic [NIB_W-1:0] fn);
        if (fn == FN_EXT_POS)      return K_EXT_POS;
        else if (fn == FN_EXT_NEG) return K_EXT_NEG;
        else if (fn == FN_OPERATE) return K_OPERATE;
        else                       return K_PLAIN;
    endfunction

    function automatic logic is_prefix(input kind_e k);
        return (k == K_EXT_POS) || (k == K_EXT_NEG);
    endfunction

endpackage

// File: rtl/ncd_byte_split.sv
module ncd_byte_split
    import ncd_pkg::*;
(
    input  logic [2*NIB_W-1:0] raw,
    output byte_fields_t       fields,
    output kind_e              kind
);
    always_comb begin
        fields.fn  = raw[2*NIB_W-1:NIB_W];
        fields.dat = raw[NIB_W-1:0];
        kind       = classify(fields.fn);
    end
endmodule

// File: rtl/ncd_operand_acc.sv
module ncd_operand_acc
    import ncd_pkg::*;
#(
    parameter int OPW  = 32,
    parameter int CNTW = 4
)(
    input  logic             clk,
    input  logic             rst,
    input  logic             step,
    input  kind_e            kind,
    input  logic [NIB_W-1:0] dat,
    output logic [OPW-1:0]   nxt_operand,
    output logic [CNTW-1:0]  cnt_q
);
    logic [OPW-1:0] acc_q;
    logic [OPW-1:0] base;

    always_comb begin
        base        = (kind == K_EXT_NEG) ? ~acc_q : acc_q;
        nxt_operand = {base[OPW-NIB_W-1:0], dat};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q <= '0;
            cnt_q <= '0;
        end else if (step) begin
            if (is_prefix(kind)) begin
                acc_q <= nxt_operand;
                cnt_q <= (cnt_q == {CNTW{1'b1}}) ? cnt_q : cnt_q + 1'b1;
            end else begin
                acc_q <= '0;
                cnt_q <= '0;
            end
        end
    end
endmodule

// File: rtl/ncd_out_stage.sv
module ncd_out_stage
    import ncd_pkg::*;
#(
    parameter int OPW  = 32,
    parameter int CNTW = 4
)(
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [NIB_W-1:0] fn,
    input  logic [OPW-1:0]   operand,
    input  logic [CNTW-1:0]  cnt,
    input  logic             is_op,
    input  logic             out_ready,
    output logic             free,
    output logic             out_valid,
    output logic [NIB_W-1:0] out_func,
    output logic [OPW-1:0]   out_operand,
    output logic [CNTW-1:0]  out_pfx_cnt,
    output logic             out_multi,
    output logic             out_is_op
);
    assign free = !out_valid || out_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid   <= 1'b0;
            out_func    <= '0;
            out_operand <= '0;
            out_pfx_cnt <= '0;
            out_multi   <= 1'b0;
            out_is_op   <= 1'b0;
        end else if (load) begin
            out_valid   <= 1'b1;
            out_func    <= fn;
            out_operand <= operand;
            out_pfx_cnt <= cnt;
            out_multi   <= (cnt != '0);
            out_is_op   <= is_op;
        end else if (out_ready) begin
            out_valid   <= 1'b0;
        end
    end
endmodule

// File: rtl/nibble_chain_decoder.sv
module nibble_chain_decoder
    import ncd_pkg::*;
#(
    parameter int OPW  = 32,
    parameter int CNTW = 4
)(
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic [7:0]       in_byte,
    output logic             in_ready,
    output logic             out_valid,
    input  logic             out_ready,
    output logic [3:0]       out_func,
    output logic [OPW-1:0]   out_operand,
    output logic [CNTW-1:0]  out_pfx_cnt,
    output logic             out_multi,
    output logic             out_is_op
);
    byte_fields_t   fields;
    kind_e          kind;
    logic           accept;
    logic           emit;
    logic [OPW-1:0] nxt_operand;
    logic [CNTW-1:0] cnt_q;

    ncd_byte_split u_split (
        .raw    (in_byte),
        .fields (fields),
        .kind   (kind)
    );

    assign accept = in_valid && in_ready;
    assign emit   = accept && !is_prefix(kind);

    ncd_operand_acc #(.OPW(OPW), .CNTW(CNTW)) u_acc (
        .clk         (clk),
        .rst         (rst),
        .step        (accept),
        .kind        (kind),
        .dat         (fields.dat),
        .nxt_operand (nxt_operand),
        .cnt_q       (cnt_q)
    );

    ncd_out_stage #(.OPW(OPW), .CNTW(CNTW)) u_out (
        .clk         (clk),
        .rst         (rst),
        .load        (emit),
        .fn          (fields.fn),
        .operand     (nxt_operand),
        .cnt         (cnt_q),
        .is_op       (kind == K_OPERATE),
        .out_ready   (out_ready),
        .free        (in_ready),
        .out_valid   (out_valid),
        .out_func    (out_func),
        .out_operand (out_operand),
        .out_pfx_cnt (out_pfx_cnt),
        .out_multi   (out_multi),
        .out_is_op   (out_is_op)
    );
endmodule

// File: rtl/ncd_checker.sv
module ncd_checker
    import ncd_pkg::*;
#(
    parameter int OPW  = 32,
    parameter int CNTW = 4
)(
    input logic            clk,
    input logic            rst,
    input logic            in_valid,
    input logic [7:0]      in_byte,
    input logic            in_ready,
    input logic            out_valid,
    input logic            out_ready,
    input logic [3:0]      out_func,
    input logic [OPW-1:0]  out_operand,
    input logic [CNTW-1:0] out_pfx_cnt,
    input logic            out_multi,
    input logic            out_is_op
);
    logic take_prefix;
    logic take_plain;
    assign take_prefix = in_valid && in_ready && is_prefix(classify(in_byte[7:4]));
    assign take_plain  = in_valid && in_ready && !is_prefix(classify(in_byte[7:4]));

    AST_STALL_BLOCKS: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |-> !in_ready);                          // R8
    AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_func)
                                       && $stable(out_operand) && $stable(out_pfx_cnt))); // R8
    AST_PREFIX_SILENT: assert property (@(posedge clk) disable iff (rst)
        take_prefix |=> !out_valid);                                       // R3
    AST_EMIT_FUNC: assert property (@(posedge clk) disable iff (rst)
        take_plain |=> (out_valid && out_func == $past(in_byte[7:4])));    // R2
    AST_EMIT_NIBBLE: assert property (@(posedge clk) disable iff (rst)
        take_plain |=> (out_operand[3:0] == $past(in_byte[3:0])));         // R2
    AST_MULTI_FLAG: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (out_multi == (out_pfx_cnt != '0)));                 // R6
    AST_OPERATE_FLAG: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (out_is_op == (out_func == FN_OPERATE)));            // R7
endmodule

bind nibble_chain_decoder ncd_checker #(.OPW(OPW), .CNTW(CNTW)) u_chk (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_byte(in_byte),
    .in_ready(in_ready), .out_valid(out_valid), .out_ready(out_ready),
    .out_func(out_func), .out_operand(out_operand), .out_pfx_cnt(out_pfx_cnt),
    .out_multi(out_multi), .out_is_op(out_is_op)
);

// File: tb/sim_nibble_chain_decoder.sv
module sim_nibble_chain_decoder;
    logic        clk = 0;
    logic        rst = 1;
    logic        in_valid = 0;
    logic [7:0]  in_byte = 0;
    logic        in_ready;
    logic        out_valid;
    logic        out_ready = 1;
    logic [3:0]  out_func;
    logic [31:0] out_operand;
    logic [3:0]  out_pfx_cnt;
    logic        out_multi;
    logic        out_is_op;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    nibble_chain_decoder u0 (.*);

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic push(input logic [7:0] b);
        @(negedge clk);
        in_valid = 1;
        in_byte  = b;
        @(posedge clk);
        @(negedge clk);
        in_valid = 0;
    endtask

    task automatic expect_out(input string req, input logic [3:0] f, input logic [31:0] op,
                              input logic [3:0] cnt, input logic isop);
        chk(out_valid === 1'b1, req, {31'd0, out_valid}, 32'd1);
        chk(out_func === f, req, {28'd0, out_func}, {28'd0, f});
        chk(out_operand === op, req, out_operand, op);
        chk(out_pfx_cnt === cnt, req, {28'd0, out_pfx_cnt}, {28'd0, cnt});
        chk(out_multi === (cnt != 0), {req, " R6 multi"}, {31'd0, out_multi}, {31'd0, cnt != 0});
        chk(out_is_op === isop, {req, " R7 flag"}, {31'd0, out_is_op}, {31'd0, isop});
    endtask

    task automatic t_reset();
        chk(out_valid === 1'b0, "R1 valid", {31'd0, out_valid}, 0);
        chk(in_ready === 1'b1, "R1 ready", {31'd0, in_ready}, 1);
    endtask

    task automatic t_single();
        push(8'h37);
        expect_out("R1 R2 single", 4'h3, 32'h7, 0, 0);
    endtask

    task automatic t_pos_chain();
        push(8'hA1);
        chk(out_valid === 1'b0, "R3 prefix silent", {31'd0, out_valid}, 0);
        push(8'hA2);
        push(8'h43);
        expect_out("R3 pos chain", 4'h4, 32'h123, 2, 0);
    endtask

    task automatic t_neg_chain();
        push(8'hBF);
        chk(out_valid === 1'b0, "R4 prefix silent", {31'd0, out_valid}, 0);
        push(8'h1F);
        expect_out("R4 neg minus one", 4'h1, 32'hFFFF_FFFF, 1, 0);
        push(8'hBA);
        push(8'h2B);
        expect_out("R4 neg chain", 4'h2, 32'hFFFF_FFAB, 1, 0);
        push(8'hA3);
        push(8'hB5);
        push(8'h76);
        expect_out("R4 mixed chain", 4'h7, 32'hFFFF_FC56, 2, 0);
    endtask

    task automatic t_clear();
        push(8'h05);
        expect_out("R5 cleared", 4'h0, 32'h5, 0, 0);
    endtask

    task automatic t_operate();
        push(8'hA1);
        push(8'hF3);
        expect_out("R7 operate", 4'hF, 32'h13, 1, 1);
    endtask

    task automatic t_overflow();
        for (int i = 1; i <= 8; i++) push({4'hA, i[3:0]});
        push(8'h59);
        expect_out("R10 truncate", 4'h5, 32'h2345_6789, 8, 0);
        for (int i = 0; i < 16; i++) push(8'hA0);
        push(8'h80);
        expect_out("R6 saturate", 4'h8, 32'h0, 15, 0);
    endtask

    task automatic t_stall();
        @(negedge clk);
        out_ready = 0;
        in_valid  = 1;
        in_byte   = 8'h52;
        @(posedge clk);
        @(negedge clk);
        in_byte = 8'h63;
        for (int i = 0; i < 3; i++) begin
            chk(in_ready === 1'b0, "R8 ready low", {31'd0, in_ready}, 0);
            chk(out_operand === 32'h2 && out_func === 4'h5, "R8 hold",
                {out_func, out_operand[27:0]}, {4'h5, 28'h2});
            @(posedge clk);
            @(negedge clk);
        end
        out_ready = 1;
        @(posedge clk);
        @(negedge clk);
        in_valid = 0;
        expect_out("R8 after release", 4'h6, 32'h3, 0, 0);
        @(posedge clk);
        @(negedge clk);
        chk(out_valid === 1'b0, "R8 single copy", {31'd0, out_valid}, 0);
    endtask

    task automatic t_stream();
        @(negedge clk);
        in_valid = 1;
        in_byte  = 8'h11;
        @(posedge clk);
        @(negedge clk);
        expect_out("R9 stream 1", 4'h1, 32'h1, 0, 0);
        in_byte = 8'hA4;
        @(posedge clk);
        @(negedge clk);
        chk(out_valid === 1'b0, "R9 prefix gap", {31'd0, out_valid}, 0);
        in_byte = 8'h22;
        @(posedge clk);
        @(negedge clk);
        expect_out("R9 stream 2", 4'h2, 32'h42, 1, 0);
        in_byte = 8'h33;
        @(posedge clk);
        @(negedge clk);
        in_valid = 0;
        expect_out("R9 stream 3", 4'h3, 32'h3, 0, 0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        t_reset();
        t_single();
        t_pos_chain();
        t_neg_chain();
        t_clear();
        t_operate();
        t_overflow();
        t_stall();
        t_stream();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule